// File: doc/BRIEF.md
# 64b/66b Block Encoder with Scrambler

This block takes one eight-lane word per clock from the media-independent side of a 10G-class link (64 data bits plus one control flag per byte lane) and turns it into a 66-bit line block. The 66-bit block is a 2-bit sync header followed by a 64-bit payload. The header says whether the block carries only data or includes control. For a control block, the block encoder looks at where the start, terminate and ordered-set characters sit among the lanes. It then picks a block type byte and packs the remaining data bytes, the 7-bit control codes and the 4-bit ordered-set codes around that byte.

The packed payload then goes through a self-synchronising scrambler, which can be removed by a parameter. The scrambler works one bit at a time, least significant bit first. It uses a 58-bit history of its own output, with taps at positions 38 and 57. The sync header bypasses the scrambler. A second parameter mirrors the payload end-for-end and swaps the two header bits, for serialisers that send the most significant bit first. Each word is taken in when the clock enable is high. The result appears one clock later and is held while the enable is low.

Top module: `blk66_encoder`

## Requirements
- R1: A word with no control flag set gives header 2'b10 and a payload equal to the input word, with lane i at payload bits 8i+7..8i.
- R2: A word with any control flag set gives header 2'b01. A pattern matching none of the other formats becomes an all-control block: type byte 0x1E, and lane i's 7-bit code at payload bit 8+7i. The code is 0x00 for byte 0x07 and 0x1E for any other byte.
- R3: Control flags 8'h01 with byte 0xFB on lane 0 give type byte 0x78, and input lanes 1..7 are copied to payload bytes 1..7.
- R4: Byte 0xFB as control on lane 4, with lanes 5..7 data, is encoded according to lanes 0..3, and any other arrangement of lanes 0..3 gives an all-control block.
  - If lanes 0..3 are all control, the result is type byte 0x33, with the codes of lanes 0..3 at bits 8..35, bits 36..39 zero, and lanes 5..7 in payload bytes 5..7.
  - If lane 0 instead holds an ordered-set control character and lanes 1..3 are data, the result is type byte 0x66.
- R5: An ordered-set control character (0x9C gives O-code 0x0, 0x5C gives O-code 0xF) on lane 0 with lanes 1..3 data puts its O-code at payload bit 32, and lanes 1..3 go to payload bytes 1..3.
  - With a second ordered set on lane 4 and lanes 5..7 data, the type byte is 0x55 and the lane-4 O-code is at bit 36.
  - With lanes 4..7 all control, the type byte is 0x4B and the codes of lanes 4..7 are at bits 36..63.
  - An ordered set on lane 4 with lanes 5..7 data and lanes 0..3 all control (lane 0 not an ordered set) gives type byte 0x2D.
- R6: If the lowest lane with a control flag holds 0xFD, in lane k, the block is a terminate block. Its type byte, for k = 0..7, is 0x87, 0x99, 0xAA, 0xB4, 0xCC, 0xD2, 0xE1 or 0xFF. Data lanes 0..k-1 go to payload bytes 1..k, and the codes of lanes above k go to bit 8+7i.
- R7: With scrambling on, payload bit i is the unscrambled bit XOR history bit 38 XOR history bit 57. Bits are taken lowest first, and each output bit is shifted into the 58-bit history at bit 0. The history is zero after reset.
- R8: With bit reversal on, payload bit i is taken from bit 63-i of the scrambled payload, and the two header bits are swapped.
- R9: The output changes one clock after a word is taken with the enable high. While the enable is low, the outputs and the scrambler history stay unchanged.
- R10: After reset the payload is zero and the header is the control value (in the reversed bit order when reversal is on).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Clock enable: take one word this cycle |
| txd | input | 64 | Lane bytes, lane 0 in bits 7..0 |
| txc | input | 8 | Per-lane control flags, bit i for lane i |
| hdr | output | 2 | Sync header, bit 0 sent first |
| payload | output | 64 | Encoded, scrambled block payload |

## Verification
The bench sweeps all 256 control-flag patterns against several rotating byte mixes that place 0x07, 0xFB, 0xFD, 0x9C, 0x5C, 0xFE and plain data bytes in every lane. These sweeps separate the format priorities, and they catch lane conditions that are misread by one. Directed words build each named format: start on lane 0 or 4, the three ordered-set layouts, and a terminate on each of the eight lanes. They check the type byte, so a wrong table entry cannot hide behind a matching packing. Every word also goes to a second instance that has scrambling and reversal turned on. That instance is compared with a bit-serial model across the whole run, so an error in the scrambler history shows up in later blocks. Enable-low gaps check that the history does not advance.

// File: rtl/blk66_pkg.sv
package blk66_pkg;
  localparam int LANES  = 8;
  localparam int BYTE_W = 8;
  localparam int DATA_W = LANES * BYTE_W;
  localparam int CODE_W = 7;
  localparam int SCR_W  = 58;

  localparam logic [1:0] HDR_DATA = 2'b10;
  localparam logic [1:0] HDR_CTRL = 2'b01;

  localparam logic [7:0] CH_IDLE  = 8'h07;
  localparam logic [7:0] CH_START = 8'hFB;
  localparam logic [7:0] CH_TERM  = 8'hFD;
  localparam logic [7:0] CH_SEQ   = 8'h9C;
  localparam logic [7:0] CH_SIG   = 8'h5C;

  typedef enum logic [3:0] {
    F_DATA, F_CTRL, F_START0, F_START4, F_OSSTART, F_OS04, F_OS0, F_OS4, F_TERM
  } blkFmt_e;

  typedef struct packed {
    blkFmt_e    fmt;
    logic [2:0] termLane;
  } encCtl_t;

  function automatic logic [7:0] termType(input logic [2:0] k);
    case (k)
      3'd0: return 8'h87;
      3'd1: return 8'h99;
      3'd2: return 8'hAA;
      3'd3: return 8'hB4;
      3'd4: return 8'hCC;
      3'd5: return 8'hD2;
      3'd6: return 8'hE1;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic isOrdSet(input logic [7:0] b);
    return (b == CH_SEQ) || (b == CH_SIG);
  endfunction
endpackage

// File: rtl/blk66_classify.sv
module blk66_classify
  import blk66_pkg::*;
(
  input  logic [DATA_W-1:0] txd,
  input  logic [LANES-1:0]  txc,
  output encCtl_t           ctl
);
  logic [7:0] laneByte [LANES];
  logic [2:0] lowLane;
  logic startLane4, os0, os4;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign laneByte[i] = txd[i*BYTE_W +: BYTE_W];
  end

  always_comb begin
    lowLane = 3'd0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (txc[i]) lowLane = 3'(i);
    end
  end

  assign startLane4 = txc[4] && (laneByte[4] == CH_START) && (txc[7:5] == 3'b000);
  assign os0 = txc[0] && isOrdSet(laneByte[0]) && (txc[3:1] == 3'b000);
  assign os4 = txc[4] && isOrdSet(laneByte[4]) && (txc[7:5] == 3'b000);

  always_comb begin
    ctl.termLane = lowLane;
    ctl.fmt      = F_CTRL;
    if (txc == '0) begin
      ctl.fmt = F_DATA;
    end else if (txc == 8'h01 && laneByte[0] == CH_START) begin
      ctl.fmt = F_START0;
    end else if (startLane4) begin
      if (os0)                     ctl.fmt = F_OSSTART;
      else if (txc[3:0] == 4'hF)   ctl.fmt = F_START4;
    end else if (os0) begin
      if (os4)                     ctl.fmt = F_OS04;
      else if (txc[7:4] == 4'hF)   ctl.fmt = F_OS0;
    end else if (os4 && txc[3:0] == 4'hF) begin
      ctl.fmt = F_OS4;
    end else if (laneByte[lowLane] == CH_TERM) begin
      ctl.fmt = F_TERM;
    end
  end
endmodule

// File: rtl/blk66_datapath.sv
module blk66_datapath
  import blk66_pkg::*;
#(
  parameter bit SCRAMBLE_EN = 1'b1,
  parameter bit BIT_REVERSE = 1'b0
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic [DATA_W-1:0] txd,
  input  encCtl_t           ctl,
  output logic [1:0]        hdr,
  output logic [DATA_W-1:0] payload
);
  localparam int CODES_W = LANES * CODE_W;
  localparam logic [1:0] HDR_RST = BIT_REVERSE ? {HDR_CTRL[0], HDR_CTRL[1]} : HDR_CTRL;

  logic [CODES_W-1:0] packedCodes;
  logic [3:0]         oCode0, oCode4;
  logic [DATA_W-1:0]  rawPay, scrPay, outPay;
  logic [1:0]         rawHdr, outHdr;
  logic [SCR_W-1:0]   scrState, scrNext;

  for (genvar i = 0; i < LANES; i++) begin : g_code
    assign packedCodes[i*CODE_W +: CODE_W] =
      (txd[i*BYTE_W +: BYTE_W] == CH_IDLE) ? 7'h00 : 7'h1E;
  end

  assign oCode0 = (txd[7:0]   == CH_SIG) ? 4'hF : 4'h0;
  assign oCode4 = (txd[39:32] == CH_SIG) ? 4'hF : 4'h0;

  always_comb begin
    rawHdr = HDR_CTRL;
    rawPay = {packedCodes, 8'h1E};
    case (ctl.fmt)
      F_DATA: begin
        rawHdr = HDR_DATA;
        rawPay = txd;
      end
      F_START0:  rawPay = {txd[63:8], 8'h78};
      F_START4:  rawPay = {txd[63:40], 4'h0, packedCodes[27:0], 8'h33};
      F_OSSTART: rawPay = {txd[63:40], 4'h0, oCode0, txd[31:8], 8'h66};
      F_OS04:    rawPay = {txd[63:40], oCode4, oCode0, txd[31:8], 8'h55};
      F_OS0:     rawPay = {packedCodes[55:28], oCode0, txd[31:8], 8'h4B};
      F_OS4:     rawPay = {txd[63:40], oCode4, packedCodes[27:0], 8'h2D};
      F_TERM: begin
        rawPay = '0;
        rawPay[7:0] = termType(ctl.termLane);
        for (int j = 0; j < LANES - 1; j++) begin
          if (j < int'(ctl.termLane)) rawPay[8 + 8*j +: 8] = txd[8*j +: 8];
        end
        for (int j = 1; j < LANES; j++) begin
          if (j > int'(ctl.termLane)) rawPay[8 + 7*j +: 7] = packedCodes[7*j +: 7];
        end
      end
      default: ;
    endcase
  end

  if (SCRAMBLE_EN) begin : g_scr
    always_comb begin
      logic [SCR_W-1:0] st;
      st = scrState;
      for (int i = 0; i < DATA_W; i++) begin
        scrPay[i] = rawPay[i] ^ st[38] ^ st[57];
        st = {st[SCR_W-2:0], scrPay[i]};
      end
      scrNext = st;
    end
  end else begin : g_noscr
    assign scrPay  = rawPay;
    assign scrNext = scrState;
  end

  if (BIT_REVERSE) begin : g_rev
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign outPay[i] = scrPay[DATA_W-1-i];
    end
    assign outHdr = {rawHdr[0], rawHdr[1]};
  end else begin : g_fwd
    assign outPay = scrPay;
    assign outHdr = rawHdr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scrState <= '0;
      hdr      <= HDR_RST;
      payload  <= '0;
    end else if (ce) begin
      scrState <= scrNext;
      hdr      <= outHdr;
      payload  <= outPay;
    end
  end
endmodule

// File: rtl/blk66_encoder.sv
module blk66_encoder
  import blk66_pkg::*;
#(
  parameter bit SCRAMBLE_EN = 1'b1,
  parameter bit BIT_REVERSE = 1'b0
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ce,
  input  logic [63:0] txd,
  input  logic [7:0]  txc,
  output logic [1:0]  hdr,
  output logic [63:0] payload
);
  encCtl_t encCtl;

  blk66_classify u_classify (
    .txd (txd),
    .txc (txc),
    .ctl (encCtl)
  );

  blk66_datapath #(
    .SCRAMBLE_EN (SCRAMBLE_EN),
    .BIT_REVERSE (BIT_REVERSE)
  ) u_datapath (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce      (ce),
    .txd     (txd),
    .ctl     (encCtl),
    .hdr     (hdr),
    .payload (payload)
  );
endmodule

// File: rtl/blk66_encoder_chk.sv
module blk66_encoder_chk #(
  parameter bit SCRAMBLE_EN = 1'b1,
  parameter bit BIT_REVERSE = 1'b0
)(
  input logic        clk,
  input logic        rst_n,
  input logic        ce,
  input logic [63:0] txd,
  input logic [7:0]  txc,
  input logic [1:0]  hdr,
  input logic [63:0] payload
);
  localparam logic [1:0] HD = BIT_REVERSE ? 2'b01 : 2'b10;
  localparam logic [1:0] HC = BIT_REVERSE ? 2'b10 : 2'b01;
  localparam bit PLAIN = !SCRAMBLE_EN && !BIT_REVERSE;

  p_hdr_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr == 2'b01) || (hdr == 2'b10));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(hdr) && $stable(payload)));

  p_data_hdr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && txc == 8'h00) |=> (hdr == HD));

  p_ctrl_hdr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && txc != 8'h00) |=> (hdr == HC));

  p_data_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (PLAIN && ce && txc == 8'h00) |=> (payload == $past(txd)));

  p_start0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (PLAIN && ce && txc == 8'h01 && txd[7:0] == 8'hFB) |=> (payload[7:0] == 8'h78));
endmodule

bind blk66_encoder blk66_encoder_chk #(
  .SCRAMBLE_EN (SCRAMBLE_EN),
  .BIT_REVERSE (BIT_REVERSE)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ce      (ce),
  .txd     (txd),
  .txc     (txc),
  .hdr     (hdr),
  .payload (payload)
);

// File: tb/tb_blk66_encoder.sv
`timescale 1ns/1ps
module tb_blk66_encoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0;
  logic [63:0] txd = '0;
  logic [7:0]  txc = '0;
  logic [1:0]  hdrA, hdrB;
  logic [63:0] payA, payB;
  int total = 0;
  int bad = 0;
  logic [57:0] mState = '0;

  always #10 clk = ~clk;

  blk66_encoder #(.SCRAMBLE_EN(1'b0), .BIT_REVERSE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .txd(txd), .txc(txc),
    .hdr(hdrA), .payload(payA));

  blk66_encoder #(.SCRAMBLE_EN(1'b1), .BIT_REVERSE(1'b1)) dutScr (
    .clk(clk), .rst_n(rst_n), .ce(ce), .txd(txd), .txc(txc),
    .hdr(hdrB), .payload(payB));

  function automatic logic [7:0] tType(input int k);
    logic [7:0] t [8] = '{8'h87, 8'h99, 8'hAA, 8'hB4, 8'hCC, 8'hD2, 8'hE1, 8'hFF};
    return t[k];
  endfunction

  function automatic logic [3:0] oc(input logic [7:0] b);
    return (b == 8'h5C) ? 4'hF : 4'h0;
  endfunction

  function automatic bit osc(input logic [7:0] b);
    return b == 8'h9C || b == 8'h5C;
  endfunction

  function automatic logic [65:0] refEnc(input logic [63:0] d, input logic [7:0] c);
    logic [7:0] b [8];
    logic [55:0] cc;
    logic [63:0] p;
    int low;
    cc = '0;
    for (int i = 0; i < 8; i++) begin
      b[i] = d[8*i +: 8];
      cc = cc | (56'(b[i] == 8'h07 ? 7'h00 : 7'h1E) << (7*i));
    end
    if (c == 8'h00) return {d, 2'b10};
    low = 0;
    for (int i = 7; i >= 0; i--) if (c[i]) low = i;
    p = {cc, 8'h1E};
    if (c == 8'h01 && b[0] == 8'hFB) p = {d[63:8], 8'h78};
    else if (c[4] && b[4] == 8'hFB && c[7:5] == 3'b0) begin
      if (c[3:0] == 4'h1 && osc(b[0])) p = {d[63:40], 4'h0, oc(b[0]), d[31:8], 8'h66};
      else if (c[3:0] == 4'hF) p = {d[63:40], 4'h0, cc[27:0], 8'h33};
    end else if (c[3:0] == 4'h1 && osc(b[0])) begin
      if (c[7:4] == 4'h1 && osc(b[4])) p = {d[63:40], oc(b[4]), oc(b[0]), d[31:8], 8'h55};
      else if (c[7:4] == 4'hF) p = {cc[55:28], oc(b[0]), d[31:8], 8'h4B};
    end else if (c[7:4] == 4'h1 && osc(b[4]) && c[3:0] == 4'hF)
      p = {d[63:40], oc(b[4]), cc[27:0], 8'h2D};
    else if (b[low] == 8'hFD) begin
      p = 64'(tType(low));
      for (int j = 0; j < low; j++) p = p | (64'(b[j]) << (8 + 8*j));
      for (int j = low + 1; j < 8; j++) p = p | (64'(cc[7*j +: 7]) << (8 + 7*j));
    end
    return {p, 2'b01};
  endfunction

  task automatic check(input string tag, input logic [65:0] act, input logic [65:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one word at a negedge, check both instances at the next negedge.
  task automatic drive(input logic [63:0] d, input logic [7:0] c, input string tag,
                       input int expType);
    logic [65:0] e;
    logic [63:0] s, r;
    txd = d; txc = c; ce = 1'b1;
    @(negedge clk);
    ce = 1'b0;
    e = refEnc(d, c);
    check(tag, {payA, hdrA}, e);
    if (expType >= 0) check({tag, " type"}, 66'(payA[7:0]), 66'(expType));
    for (int i = 0; i < 64; i++) begin
      s[i] = e[i+2] ^ mState[38] ^ mState[57];
      mState = {mState[56:0], s[i]};
    end
    for (int i = 0; i < 64; i++) r[i] = s[63-i];
    check({tag, " R7 R8"}, {payB, hdrB}, {r, e[0], e[1]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] cs [8] = '{8'h07, 8'hFB, 8'hFD, 8'h9C, 8'h5C, 8'hFE, 8'h3A, 8'hC5};
    logic [63:0] d;
    logic [65:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 plain", {payA, hdrA}, {64'h0, 2'b01});
    check("R10 reversed", {payB, hdrB}, {64'h0, 2'b10});

    // R1 data
    drive(64'h0123456789ABCDEF, 8'h00, "R1", 8'hEF);
    drive(64'h07FB_FD9C_5C00_FFAA, 8'h00, "R1 ctlchars", -1);
    // R2 all-control and unmatched
    drive({8{8'h07}}, 8'hFF, "R2 idle", 8'h1E);
    check("R2 idle payload", 66'(payA), 66'h1E);
    drive({8{8'hFE}}, 8'hFF, "R2 error", 8'h1E);
    drive(64'h0707_0707_FD11_0722, 8'h1A, "R2 unmatched", 8'h1E);
    // R3
    drive(64'hD5555555555555FB, 8'h01, "R3", 8'h78);
    // R4
    drive(64'h111111FB07070707, 8'h1F, "R4 start4", 8'h33);
    drive(64'h222222FB3333339C, 8'h11, "R4 os-start seq", 8'h66);
    drive(64'h222222FB3333335C, 8'h11, "R4 os-start sig", 8'h66);
    drive(64'h111111FB07070722, 8'h1E, "R4 bad low lanes", 8'h1E);
    // R5
    drive(64'h070707074444445C, 8'hF1, "R5 os0", 8'h4B);
    drive(64'h5555559C07070707, 8'h1F, "R5 os4", 8'h2D);
    drive(64'h6666665C7777779C, 8'h11, "R5 os04", 8'h55);
    // R6 terminate on every lane
    for (int k = 0; k < 8; k++) begin
      d = {8{8'h07}};
      for (int j = 0; j < k; j++) d[8*j +: 8] = 8'(8'hA0 + j);
      d[8*k +: 8] = 8'hFD;
      drive(d, 8'(8'hFF << k), $sformatf("R6 lane%0d", k), int'(tType(k)));
    end
    // R9 hold with enable low
    held = {payA, hdrA};
    txd = 64'h1234; txc = 8'h00; ce = 1'b0;
    @(negedge clk);
    check("R9 hold plain", {payA, hdrA}, held);
    drive(64'hCAFEF00D12345678, 8'h00, "R9 after gap", -1);
    // Sweep of all control patterns with rotating byte mixes
    for (int s = 0; s < 5; s++) begin
      for (int c = 0; c < 256; c++) begin
        for (int i = 0; i < 8; i++) d[8*i +: 8] = cs[(s*7 + i*3 + c) % 8];
        drive(d, 8'(c), "R2 R4 R5 R6 sweep", -1);
      end
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule